// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate

This block decides whether one peripheral clock runs. Two sources can control it: a hardware request line from the peripheral's own idle logic, and an enable bit that software sets in a 32-bit control register. A select bit in the same register chooses which source is in charge, and software can change that choice at run time. The block produces a clock-enable for a latch-free enable-based gating cell.

The block also keeps a status bit in the register. This bit shows the gate state that has passed through a two-flop synchronizer. Software can write the requested state and then poll the status bit until it matches.

Parameters set the bit positions of the status, enable and select fields, and the variant. The variants are hardware-only, software-only, or both with selection. A field that does not exist in the chosen variant cannot be written and reads as zero.

Top module: `clk_gate_ctl`

## Requirements
- R1: After reset, the dual-source variant has the enable bit (bit 1) at 1, the select bit (bit 2) at 1 (software control) and `clk_en` at 1. The status bit (bit 0) reads 0 until the synchronizer fills.
- R2: When the select bit is 1, `clk_en` equals the enable bit and does not depend on `hw_req`.
- R3: When the select bit is 0, `clk_en` equals `hw_req` in the same cycle, whatever the enable bit holds.
- R4: The status bit (bit 0) equals the value `clk_en` had two rising edges earlier. After a change of `clk_en` it flips at the second rising edge.
- R5: A write (`wr_en` high) loads the enable bit from `wdata[1]` and the select bit from `wdata[2]` at the rising edge. The new values read back from the next cycle on.
- R6: The status bit cannot be written. Register bits other than 0, 1 and 2 read 0 whatever was written to them.
- R7: In the software-only variant, the select bit reads 0 and cannot be written, and `clk_en` always equals the enable bit.
- R8: In the hardware-only variant, the enable and select bits read 0 and cannot be written, and `clk_en` always equals `hw_req`.
- R9: A write that changes the select bit moves gating control to the other source from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the control logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (status, enable, select) |
| hw_req | input | 1 | Hardware run request from the peripheral |
| clk_en | output | 1 | Enable for the gating cell |
| gate_status | output | 1 | Synchronized gate state, same as the status bit |

## Verification
`clk_en` responds to `hw_req` within the same cycle, and to a register write from the edge that takes the write. The readback of the enable and select bits also changes at that edge. The status bit is due two rising edges after a change of `clk_en`. The bench changes inputs on the falling edge and keeps a reference model of the register and a two-deep history of the expected enable. It compares every output at the next falling edge, so each check falls half a cycle after the edge that produced its value.

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl #(
  parameter int REG_W    = 32,
  parameter int STAT_POS = 0,
  parameter int EN_POS   = 1,
  parameter int SEL_POS  = 2,
  parameter bit HAS_HW   = 1'b1,
  parameter bit HAS_SW   = 1'b1,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             hw_req,
  output logic             clk_en,
  output logic             gate_status
);
  localparam bit DUAL = HAS_HW && HAS_SW;

  logic                sw_en_q;
  logic                sel_q;
  logic                hw_mode;
  logic [SYNC_LEN-1:0] sync_q;
  logic [1:0]          warm_q;

  generate
    if (HAS_SW) begin : g_en
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     sw_en_q <= 1'b1;
        else if (wr_en) sw_en_q <= wdata[EN_POS];
    end else begin : g_no_en
      assign sw_en_q = 1'b0;
    end

    if (DUAL) begin : g_sel
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     sel_q <= 1'b1;
        else if (wr_en) sel_q <= wdata[SEL_POS];
    end else begin : g_no_sel
      assign sel_q = 1'b0;
    end
  endgenerate

  assign hw_mode = HAS_HW && (!HAS_SW || !sel_q);
  assign clk_en  = hw_mode ? hw_req : sw_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], clk_en};

  assign gate_status = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;

  always_comb begin
    rdata = '0;
    rdata[STAT_POS] = gate_status;
    if (HAS_SW) rdata[EN_POS]  = sw_en_q;
    if (DUAL)   rdata[SEL_POS] = sel_q;
  end

  generate
    if (HAS_SW) begin : g_sw_chk
      p_sw_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mode |-> (clk_en == rdata[EN_POS]));
      p_sw_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_mode && !wr_en) |=> $stable(clk_en));
      p_wr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[EN_POS] == $past(wdata[EN_POS])));
    end
    if (HAS_HW) begin : g_hw_chk
      p_hw_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode |-> (clk_en == hw_req));
    end
    if (DUAL) begin : g_sel_chk
      p_sel_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[SEL_POS]) |=> hw_mode);
    end
    if (SYNC_LEN == 2) begin : g_lag_chk
      p_status_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (gate_status == $past(clk_en, 2)));
    end
  endgenerate
endmodule

// File: tb/clk_gate_ctl_bench.sv
module clk_gate_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam bit HHW [3] = '{1'b1, 1'b0, 1'b1};
  localparam bit HSW [3] = '{1'b1, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        hw_req = 1'b0;
  logic [31:0] rd [3];
  logic        ce [3];
  logic        st [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_gate_ctl u_clk_gate_ctl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rd[0]), .hw_req(hw_req), .clk_en(ce[0]), .gate_status(st[0]));
  clk_gate_ctl #(.HAS_HW(1'b0), .HAS_SW(1'b1)) u_sw_only (.clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wdata(wdata), .rdata(rd[1]), .hw_req(hw_req), .clk_en(ce[1]),
    .gate_status(st[1]));
  clk_gate_ctl #(.HAS_HW(1'b1), .HAS_SW(1'b0)) u_hw_only (.clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wdata(wdata), .rdata(rd[2]), .hw_req(hw_req), .clk_en(ce[2]),
    .gate_status(st[2]));

  logic m_en [3];
  logic m_sel [3];
  logic h1 [3];
  logic h2 [3];

  function automatic logic exp_eff(int i, logic hw);
    logic hwm;
    hwm = HHW[i] && (!HSW[i] || !m_sel[i]);
    return hwm ? hw : m_en[i];
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    logic [31:0] v;
    v = '0;
    v[0] = h2[i];
    v[1] = HSW[i] ? m_en[i] : 1'b0;
    v[2] = (HSW[i] && HHW[i]) ? m_sel[i] : 1'b0;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) begin
        m_en[i] <= HSW[i];
        m_sel[i] <= HSW[i] && HHW[i];
        h1[i] <= 1'b0;
        h2[i] <= 1'b0;
      end else begin
        h1[i] <= exp_eff(i, hw_req);
        h2[i] <= h1[i];
        if (wr_en && HSW[i]) m_en[i] <= wdata[1];
        if (wr_en && HSW[i] && HHW[i]) m_sel[i] <= wdata[2];
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_all();
    chk(m_sel[0] ? "R2 clk_en" : "R3 clk_en", 32'(ce[0]), 32'(exp_eff(0, hw_req)));
    chk("R4 status", 32'(st[0]), 32'(h2[0]));
    chk("R5/R6 rdata", rd[0], exp_rd(0));
    chk("R7 sw-only clk_en", 32'(ce[1]), 32'(exp_eff(1, hw_req)));
    chk("R7 sw-only rdata", rd[1], exp_rd(1));
    chk("R8 hw-only clk_en", 32'(ce[2]), 32'(hw_req));
    chk("R8 hw-only rdata", rd[2], exp_rd(2));
  endtask

  task automatic cycle(logic w, logic [31:0] d, logic hw);
    wr_en = w; wdata = d; hw_req = hw;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R1 reset rdata", rd[0], 32'h6);
    chk("R1 reset clk_en", 32'(ce[0]), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    cycle(1'b0, '0, 1'b0);
    cycle(1'b0, '0, 1'b0);
    chk("R1 status after fill", 32'(st[0]), 32'd1);

    cycle(1'b1, 32'h0000_0004, 1'b1);
    chk("R2 sw off ignores hw_req", 32'(ce[0]), 32'd0);
    cycle(1'b0, '0, 1'b1);
    chk("R4 status one edge later", 32'(st[0]), 32'd1);
    cycle(1'b0, '0, 1'b1);
    chk("R4 status two edges later", 32'(st[0]), 32'd0);

    cycle(1'b1, 32'h0000_0002, 1'b0);
    chk("R9 to hw control, req low", 32'(ce[0]), 32'd0);
    cycle(1'b0, '0, 1'b1);
    chk("R3 hw req high", 32'(ce[0]), 32'd1);
    cycle(1'b1, 32'h0000_0004, 1'b1);
    chk("R9 back to sw, en low", 32'(ce[0]), 32'd0);

    cycle(1'b1, 32'hFFFF_FFFE, 1'b0);
    chk("R6 unused bits read 0", rd[0] & 32'hFFFF_FFF8, 32'd0);
    cycle(1'b1, 32'h0000_0001, 1'b0);
    chk("R6 status not writable", rd[0] & 32'h1, 32'(h2[0]));

    for (int n = 0; n < 3000; n++)
      cycle(1'($urandom_range(0, 3) == 0), $urandom(), 1'($urandom()));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule